// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

A general-purpose I/O port of up to 32 lines behind a 32-bit register port with word addresses. Each line can be turned into an output by its direction bit. One data location both sets the driven values and returns the sampled line levels. A write-mask register decides which data bits a write may change.

Every line runs through a two-flop synchronizer. A transition in either direction then raises that line's bit in a change register, which software clears by writing ones. An enable register masks the change bits. The single interrupt output is high while any enabled change bit is set, so a parent interrupt controller can read change AND enable to find the lines that need service. A type register is plain storage. Bits above the configured line count, and addresses that are not defined, read as zero and ignore writes.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After reset, direction, data output, enable, change and type all read 0, the write mask reads all implemented bits as 1, `pad_oe` is 0 and `irq` is 0.
- R2: Word address 0 is direction. A 1 in bit i drives `pad_oe[i]` high and makes line i an output. The new value appears on `pad_oe` in the cycle after the write.
- R3: A write to word address 1 (data) updates `pad_out[i]` only where bit i of the write mask (word address 4) is 1. Other output bits keep their value.
- R4: A read of word address 1 returns the line levels on `pad_in`, delayed by two clock cycles through the synchronizer.
- R5: Bit i of the change register (word address 3) sets one cycle after the synchronized level of line i differs from its previous value. This happens for both rising and falling transitions, and the bit stays set otherwise.
- R6: Writing 1 to a bit of the change register clears it. Writing 0 leaves it unchanged.
- R7: When a new transition and a clearing write hit the same change bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly while some bit is set in both change and enable (word address 2). Enable reads back what was written.
- R9: Register bits at positions NLINES and above read as 0 and ignore writes.
- R10: Word address 5 (type) is read/write storage with no effect on detection. Word addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| pad_in | input | NLINES | Line levels from the pads |
| pad_out | output | NLINES | Output values to the pads |
| pad_oe | output | NLINES | Output enables (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
Edge detection is tried with a rising pair of lines, then a single falling line, then a line toggled again so that its transition lands in the same cycle as a clearing write. These cases separate rise-only or fall-only detectors from both-edge ones, and they show whether the clear or the edge takes priority. Data writes are made once with a full mask and once with a partial mask, which shows whether the mask gates the update. Enable is set with the change bit both present and cleared, which checks the interrupt in both directions. All-ones writes to every register show the bits above the line count and the undefined addresses staying zero.

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq
);
  localparam logic [31:0] LMASK = (NLINES >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NLINES) - 32'd1);
  localparam logic [2:0] A_DIR = 3'd0, A_DAT = 3'd1, A_IEN = 3'd2,
                         A_CHG = 3'd3, A_WMK = 3'd4, A_TYP = 3'd5;

  logic [31:0] dir_q, out_q, ien_q, chg_q, wmask_q, type_q;
  logic [NLINES-1:0] s1_q, s2_q, prev_q;
  logic [31:0] lvl, edge_v;
  logic wr;

  assign wr     = bus_sel & bus_we;
  assign lvl    = 32'(s2_q);
  assign edge_v = 32'(s2_q ^ prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      chg_q   <= '0;
      wmask_q <= LMASK;
      type_q  <= '0;
    end else begin
      if (wr && bus_addr == A_DIR) dir_q <= bus_wdata & LMASK;
      if (wr && bus_addr == A_DAT) out_q <= ((out_q & ~wmask_q) | (bus_wdata & wmask_q)) & LMASK;
      if (wr && bus_addr == A_IEN) ien_q <= bus_wdata & LMASK;
      if (wr && bus_addr == A_WMK) wmask_q <= bus_wdata & LMASK;
      if (wr && bus_addr == A_TYP) type_q <= bus_wdata & LMASK;
      if (wr && bus_addr == A_CHG) chg_q <= ((chg_q & ~bus_wdata) | edge_v) & LMASK;
      else                         chg_q <= (chg_q | edge_v) & LMASK;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_DAT:   bus_rdata = lvl;
      A_IEN:   bus_rdata = ien_q;
      A_CHG:   bus_rdata = chg_q;
      A_WMK:   bus_rdata = wmask_q;
      A_TYP:   bus_rdata = type_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out = out_q[NLINES-1:0];
  assign pad_oe  = dir_q[NLINES-1:0];
  assign irq     = |(chg_q & ien_q);
endmodule

module gpio_edge_ctl_chk #(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NLINES-1:0] pad_out,
  input logic [NLINES-1:0] pad_oe,
  input logic              irq,
  input logic [31:0]       chg_q,
  input logic [31:0]       ien_q,
  input logic [31:0]       wmask_q,
  input logic [31:0]       edge_v
);
  localparam logic [31:0] LM = (NLINES >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NLINES) - 32'd1);

  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd0) |=> (32'(pad_oe) == ($past(bus_wdata) & LM)));

  a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd1) |=> ((32'(pad_out ^ $past(pad_out)) & ~$past(wmask_q)) == 32'd0));

  a_r5_stable_chg: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v == 32'd0 && !(bus_sel && bus_we && bus_addr == 3'd3)) |=> $stable(chg_q));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 3'd3) |=> ((chg_q & $past(bus_wdata) & ~$past(edge_v)) == 32'd0));

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_v != 32'd0) |=> ((chg_q & $past(edge_v)) == $past(edge_v)));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 32'd0) |-> !irq);

  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr > 3'd5) |-> (bus_rdata == 32'd0));
endmodule

bind gpio_edge_ctl gpio_edge_ctl_chk #(.NLINES(NLINES)) u_chk (.*);

// File: tb/sim_gpio_edge_ctl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctl;
  localparam int NL = 24;
  localparam logic [31:0] LM = 32'h00FF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NL-1:0] pad_in = '0, pad_out, pad_oe;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exq[$];
  string tq[$];

  always #2.5 clk = ~clk;

  gpio_edge_ctl #(.NLINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_sel && !bus_we && exq.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exq.pop_front();
      t = tq.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exq.push_back(e); tq.push_back(tag);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    rd(3'd0, 32'd0, "R1 dir");
    rd(3'd1, 32'd0, "R1 data");
    rd(3'd2, 32'd0, "R1 enable");
    rd(3'd3, 32'd0, "R1 change");
    rd(3'd4, LM, "R1 wmask");
    rd(3'd5, 32'd0, "R1 type");
    chk("R1 pad_oe", 32'(pad_oe), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    wr(3'd0, 32'h0000_F0F0);
    chk("R2 pad_oe", 32'(pad_oe), 32'h0000_F0F0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, LM, "R9 dir upper bits");
    chk("R2 pad_oe all", 32'(pad_oe), LM);

    wr(3'd1, 32'h0012_3456);
    chk("R3 full mask", 32'(pad_out), 32'h0012_3456);
    wr(3'd4, 32'h0000_00FF);
    wr(3'd1, 32'h00AB_CDEF);
    chk("R3 partial mask", 32'(pad_out), 32'h0012_34EF);
    rd(3'd4, 32'h0000_00FF, "R3 wmask readback");
    wr(3'd4, 32'hFFFF_FFFF);

    pad_in = 24'h000081;
    idle(4);
    rd(3'd1, 32'h0000_0081, "R4 data level");
    rd(3'd3, 32'h0000_0081, "R5 rising");
    chk("R8 irq masked", 32'(irq), 32'd0);

    wr(3'd2, 32'h0000_0001);
    chk("R8 irq on", 32'(irq), 32'd1);
    rd(3'd2, 32'h0000_0001, "R8 enable readback");
    wr(3'd3, 32'h0000_0000);
    rd(3'd3, 32'h0000_0081, "R6 write zero");
    wr(3'd3, 32'h0000_0001);
    rd(3'd3, 32'h0000_0080, "R6 clear one");
    chk("R8 irq off", 32'(irq), 32'd0);
    wr(3'd3, 32'h0000_0080);
    rd(3'd3, 32'd0, "R6 clear all");

    pad_in = 24'h000001;
    idle(4);
    rd(3'd3, 32'h0000_0080, "R5 falling");

    @(posedge clk); #1;
    pad_in = 24'h000081;
    @(posedge clk); #1;
    wr(3'd3, 32'h0000_0080);
    rd(3'd3, 32'h0000_0080, "R7 edge beats clear");
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'd0, "R6 cleared");

    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, LM, "R10 type storage");
    pad_in = 24'h000085;
    idle(4);
    rd(3'd3, 32'h0000_0004, "R10 type no effect");
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, LM, "R9 enable upper bits");
    chk("R8 irq line2", 32'(irq), 32'd1);

    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, 32'd0, "R10 undef 6");
    rd(3'd7, 32'd0, "R10 undef 7");
    rd(3'd3, 32'h0000_0004, "R10 undef write harmless");
    idle(2);
    if (exq.size() != 0) chk("scoreboard drained", 32'(exq.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule